// File: doc/BRIEF.md
# Compressed Opcode Page Stack Controller

This block tracks which alternate opcode page is in force for a 16-bit compressed instruction stream. The instruction decoder gives it page-control events: push a new page with an activation length, drop the top page, or return to the default instruction set. It also gives a strobe for each retired instruction and a taken-branch indication. The controller keeps a four-deep stack of page/countdown entries. It counts the top entry down as ordinary instructions retire and removes entries that run out or that a taken branch cancels. A length code of all ones marks a page that never counts down and survives branches.

The active page number and a default-instruction-set flag are the outputs the decoder uses. The whole activation state (entries, depth and a sticky overflow flag) appears as one 32-bit control/status word. Software can read that word and write it back, so a caller can save the state around a call and restore it afterwards.

Top module: `opg_stack_ctrl`

## Requirements
- R1: After `rst_n` is released, `csr_rdata_o` is 0, `default_isa_o` is 1, `active_page_o` is 0 and `overflow_o` is 0.
- R2: Status word layout: stack slot k (k = 0 is the bottom) holds the length in bits [7k+3:7k] and the page in bits [7k+6:7k+4]. The depth is in bits [30:28] and the overflow flag in bit 31. A push with a nonzero length stores {page, length} in slot `depth` and increments the depth. A push with length 0 changes nothing.
- R3: A push while the depth is 4 leaves the stack unchanged and sets `overflow_o`. The flag stays set until a status write clears bit 31 or `rst_n` is asserted.
- R4: A retire strobe in a cycle with no page-control event, no taken branch and no status write decrements the top entry's length. When the result is 0 (or the length already was 0), that slot is cleared to zero and the depth drops by one. A page-control event in the same cycle as a retire takes the place of the countdown.
- R5: A top entry with length 15 (all ones) is never counted down.
- R6: A pop clears the top slot to zero and decrements the depth. A pop at depth 0 has no effect.
- R7: A reset-to-default event clears every slot and sets the depth to 0. It leaves the overflow flag as it was.
- R8: A taken branch removes every entry whose length is not 15. The remaining permanent entries keep their relative order, packed from slot 0 up. All slots above them read 0. No countdown happens in that cycle.
- R9: A status write loads all slots, the depth and the overflow flag from `csr_wdata_i`. A depth value above 4 is stored as 4. The write overrides every other event in the same cycle.
- R10: At depth 0, `active_page_o` is 0 and `default_isa_o` is 1. Otherwise `active_page_o` is the page of slot depth-1 and `default_isa_o` is 0.
- R11: When several events coincide, only the one with the highest priority acts. The order is: status write, then reset-to-default, then pop, then push, then taken branch, then retire.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| retire_i | input | 1 | One instruction retired this cycle |
| ctl_push_i | input | 1 | Push-page control event |
| push_page_i | input | 3 | Page number to push |
| push_len_i | input | 4 | Activation length to push (15 = permanent) |
| ctl_pop_i | input | 1 | Drop the top page |
| ctl_reset_i | input | 1 | Return to the default instruction set |
| branch_taken_i | input | 1 | A branch was taken this cycle |
| csr_we_i | input | 1 | Status word write strobe |
| csr_wdata_i | input | 32 | Status word write data |
| csr_rdata_o | output | 32 | Current status word |
| active_page_o | output | 3 | Page in force (0 when default) |
| default_isa_o | output | 1 | Default instruction set in force |
| overflow_o | output | 1 | Sticky push-overflow flag |

## Verification
Every event acts on the state registers at the rising edge that ends its cycle. All four outputs are decoded from those registers without further delay, so each result is due exactly one edge after the stimulus. The driver applies one stimulus per cycle at the falling edge and queues the expected status word, page, default flag and overflow flag from its own model. The monitor takes one queued item 3 ns after each rising edge and compares it there, so every comparison lands on the first edge that can show the effect. Coincident events are driven in the same cycle, which puts the priority order and the countdown suppression on that single edge.

// File: rtl/opg_pkg.sv
package opg_pkg;
  parameter int unsigned PG_W  = 3;
  parameter int unsigned LN_W  = 4;
  parameter int unsigned STK_N = 4;

  localparam int unsigned ENT_W   = PG_W + LN_W;
  localparam int unsigned IDX_W   = $clog2(STK_N);
  localparam int unsigned DEP_W   = $clog2(STK_N + 1);
  localparam int unsigned DEP_LSB = STK_N * ENT_W;
  localparam int unsigned OVF_BIT = DEP_LSB + DEP_W;
  localparam int unsigned CSR_W   = OVF_BIT + 1;

  localparam logic [LN_W-1:0]  LEN_PERM = '1;
  localparam logic [DEP_W-1:0] DEP_MAX  = DEP_W'(STK_N);

  typedef struct packed {
    logic [PG_W-1:0] page;
    logic [LN_W-1:0] len;
  } ent_t;

  typedef enum logic [2:0] {
    OP_IDLE, OP_CSR, OP_RESET, OP_POP, OP_PUSH, OP_FLUSH, OP_TICK
  } op_e;

  function automatic logic is_perm(input logic [LN_W-1:0] l);
    return l == LEN_PERM;
  endfunction

  // Length after one retired instruction; 0 means the entry expires.
  function automatic logic [LN_W-1:0] len_after_tick(input logic [LN_W-1:0] l);
    if (is_perm(l)) return l;
    if (l == '0) return '0;
    return l - 1'b1;
  endfunction

  function automatic logic [DEP_W-1:0] clamp_depth(input logic [DEP_W-1:0] d);
    return (d > DEP_MAX) ? DEP_MAX : d;
  endfunction
endpackage

// File: rtl/opg_event_arb.sv
module opg_event_arb
  import opg_pkg::*;
(
  input  logic            csr_we_i,
  input  logic            ctl_reset_i,
  input  logic            ctl_pop_i,
  input  logic            ctl_push_i,
  input  logic [LN_W-1:0] push_len_i,
  input  logic            branch_taken_i,
  input  logic            retire_i,
  output op_e             op_o
);
  // Single winner per cycle; a zero-length push is a control event that does nothing.
  always_comb begin
    if (csr_we_i)            op_o = OP_CSR;
    else if (ctl_reset_i)    op_o = OP_RESET;
    else if (ctl_pop_i)      op_o = OP_POP;
    else if (ctl_push_i)     op_o = (push_len_i == '0) ? OP_IDLE : OP_PUSH;
    else if (branch_taken_i) op_o = OP_FLUSH;
    else if (retire_i)       op_o = OP_TICK;
    else                     op_o = OP_IDLE;
  end
endmodule

// File: rtl/opg_stack_next.sv
module opg_stack_next
  import opg_pkg::*;
(
  input  op_e                    op_i,
  input  ent_t [STK_N-1:0]       stk_i,
  input  logic [DEP_W-1:0]       depth_i,
  input  logic                   ovf_i,
  input  ent_t                   push_ent_i,
  input  logic [CSR_W-1:0]       csr_wdata_i,
  output ent_t [STK_N-1:0]       stk_o,
  output logic [DEP_W-1:0]       depth_o,
  output logic                   ovf_o,
  output logic                   ev_push_ok_o,
  output logic                   ev_push_drop_o,
  output logic                   ev_expire_o,
  output logic                   ev_flush_o
);
  logic [IDX_W-1:0] top_idx;
  logic [IDX_W-1:0] new_idx;
  logic [LN_W-1:0]  tick_len;
  logic [DEP_W-1:0] keep_cnt;

  assign top_idx  = IDX_W'(depth_i - 1'b1);
  assign new_idx  = IDX_W'(depth_i);
  assign tick_len = len_after_tick(stk_i[top_idx].len);

  always_comb begin
    stk_o          = stk_i;
    depth_o        = depth_i;
    ovf_o          = ovf_i;
    ev_push_ok_o   = 1'b0;
    ev_push_drop_o = 1'b0;
    ev_expire_o    = 1'b0;
    ev_flush_o     = 1'b0;
    keep_cnt       = '0;
    unique case (op_i)
      OP_CSR: begin
        for (int i = 0; i < STK_N; i++) begin
          stk_o[IDX_W'(i)] = csr_wdata_i[i*ENT_W +: ENT_W];
        end
        depth_o = clamp_depth(csr_wdata_i[DEP_LSB +: DEP_W]);
        ovf_o   = csr_wdata_i[OVF_BIT];
      end
      OP_RESET: begin
        stk_o   = '0;
        depth_o = '0;
      end
      OP_POP: begin
        if (depth_i != '0) begin
          stk_o[top_idx] = '0;
          depth_o        = depth_i - 1'b1;
        end
      end
      OP_PUSH: begin
        if (depth_i < DEP_MAX) begin
          stk_o[new_idx] = push_ent_i;
          depth_o        = depth_i + 1'b1;
          ev_push_ok_o   = 1'b1;
        end else begin
          ovf_o          = 1'b1;
          ev_push_drop_o = 1'b1;
        end
      end
      OP_FLUSH: begin
        ev_flush_o = 1'b1;
        stk_o      = '0;
        for (int i = 0; i < STK_N; i++) begin
          if (DEP_W'(i) < depth_i && is_perm(stk_i[IDX_W'(i)].len)) begin
            stk_o[IDX_W'(keep_cnt)] = stk_i[IDX_W'(i)];
            keep_cnt = keep_cnt + 1'b1;
          end
        end
        depth_o = keep_cnt;
      end
      OP_TICK: begin
        if (depth_i != '0) begin
          if (tick_len == '0) begin
            stk_o[top_idx] = '0;
            depth_o        = depth_i - 1'b1;
            ev_expire_o    = 1'b1;
          end else begin
            stk_o[top_idx].len = tick_len;
          end
        end
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/opg_csr_view.sv
module opg_csr_view
  import opg_pkg::*;
(
  input  ent_t [STK_N-1:0] stk_i,
  input  logic [DEP_W-1:0] depth_i,
  input  logic             ovf_i,
  output logic [CSR_W-1:0] rdata_o,
  output logic [PG_W-1:0]  page_o,
  output logic             dflt_o
);
  logic [IDX_W-1:0] top_idx;

  assign rdata_o = {ovf_i, depth_i, stk_i};
  assign dflt_o  = (depth_i == '0);
  assign top_idx = IDX_W'(depth_i - 1'b1);
  assign page_o  = dflt_o ? '0 : stk_i[top_idx].page;
endmodule

// File: rtl/opg_stack_ctrl.sv
module opg_stack_ctrl
  import opg_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             retire_i,
  input  logic             ctl_push_i,
  input  logic [PG_W-1:0]  push_page_i,
  input  logic [LN_W-1:0]  push_len_i,
  input  logic             ctl_pop_i,
  input  logic             ctl_reset_i,
  input  logic             branch_taken_i,
  input  logic             csr_we_i,
  input  logic [CSR_W-1:0] csr_wdata_i,
  output logic [CSR_W-1:0] csr_rdata_o,
  output logic [PG_W-1:0]  active_page_o,
  output logic             default_isa_o,
  output logic             overflow_o
);
  op_e              op;
  ent_t [STK_N-1:0] stk_q, stk_d;
  logic [DEP_W-1:0] depth_q, depth_d;
  logic             ovf_q, ovf_d;
  ent_t             push_ent;

  // Named internal events, observed by the bound checker.
  logic ev_push_ok, ev_push_drop, ev_expire, ev_flush;

  assign push_ent = '{page: push_page_i, len: push_len_i};

  opg_event_arb u_arb (
    .csr_we_i       (csr_we_i),
    .ctl_reset_i    (ctl_reset_i),
    .ctl_pop_i      (ctl_pop_i),
    .ctl_push_i     (ctl_push_i),
    .push_len_i     (push_len_i),
    .branch_taken_i (branch_taken_i),
    .retire_i       (retire_i),
    .op_o           (op)
  );

  opg_stack_next u_next (
    .op_i           (op),
    .stk_i          (stk_q),
    .depth_i        (depth_q),
    .ovf_i          (ovf_q),
    .push_ent_i     (push_ent),
    .csr_wdata_i    (csr_wdata_i),
    .stk_o          (stk_d),
    .depth_o        (depth_d),
    .ovf_o          (ovf_d),
    .ev_push_ok_o   (ev_push_ok),
    .ev_push_drop_o (ev_push_drop),
    .ev_expire_o    (ev_expire),
    .ev_flush_o     (ev_flush)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stk_q   <= '0;
      depth_q <= '0;
      ovf_q   <= 1'b0;
    end else begin
      stk_q   <= stk_d;
      depth_q <= depth_d;
      ovf_q   <= ovf_d;
    end
  end

  opg_csr_view u_view (
    .stk_i   (stk_q),
    .depth_i (depth_q),
    .ovf_i   (ovf_q),
    .rdata_o (csr_rdata_o),
    .page_o  (active_page_o),
    .dflt_o  (default_isa_o)
  );

  assign overflow_o = ovf_q;
endmodule

// File: rtl/opg_stack_chk.sv
module opg_stack_chk
  import opg_pkg::*;
(
  input logic             clk,
  input logic             rst_n,
  input logic             retire_i,
  input logic             ctl_push_i,
  input logic             ctl_pop_i,
  input logic             ctl_reset_i,
  input logic             branch_taken_i,
  input logic             csr_we_i,
  input logic [CSR_W-1:0] csr_wdata_i,
  input logic [CSR_W-1:0] csr_rdata_o,
  input logic [PG_W-1:0]  active_page_o,
  input logic             default_isa_o,
  input logic             overflow_o,
  input logic             ev_push_ok,
  input logic             ev_push_drop,
  input logic             ev_expire,
  input logic             ev_flush
);
  logic [DEP_W-1:0] dep;
  logic [LN_W-1:0]  top_len;
  logic [PG_W-1:0]  top_page;
  logic             plain_retire;

  assign dep = csr_rdata_o[DEP_LSB +: DEP_W];
  assign plain_retire = retire_i && !ctl_push_i && !ctl_pop_i && !ctl_reset_i
                        && !branch_taken_i && !csr_we_i;

  always_comb begin
    top_len  = '0;
    top_page = '0;
    for (int k = 0; k < STK_N; k++) begin
      if (DEP_W'(k + 1) == dep) begin
        top_len  = csr_rdata_o[k*ENT_W +: LN_W];
        top_page = csr_rdata_o[k*ENT_W + LN_W +: PG_W];
      end
    end
  end

  assert_depth_bound_R9: assert property (@(posedge clk) disable iff (!rst_n)
    dep <= DEP_MAX);

  assert_default_view_R10: assert property (@(posedge clk) disable iff (!rst_n)
    default_isa_o == (dep == '0));

  assert_page_view_R10: assert property (@(posedge clk) disable iff (!rst_n)
    active_page_o == ((dep == '0) ? '0 : top_page));

  assert_push_ok_R2: assert property (@(posedge clk) disable iff (!rst_n)
    ev_push_ok |=> !default_isa_o && dep == DEP_W'($past(dep) + 1'b1));

  assert_push_drop_R3: assert property (@(posedge clk) disable iff (!rst_n)
    ev_push_drop |=> overflow_o && dep == $past(dep));

  assert_ovf_sticky_R3: assert property (@(posedge clk) disable iff (!rst_n)
    overflow_o && !csr_we_i |=> overflow_o);

  assert_expire_R4: assert property (@(posedge clk) disable iff (!rst_n)
    ev_expire |=> dep == DEP_W'($past(dep) - 1'b1));

  assert_perm_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    plain_retire && dep != '0 && top_len == LEN_PERM |=> $stable(csr_rdata_o));

  assert_reset_clear_R7: assert property (@(posedge clk) disable iff (!rst_n)
    ctl_reset_i && !csr_we_i |=> default_isa_o && csr_rdata_o[OVF_BIT-1:0] == '0);

  assert_flush_R8: assert property (@(posedge clk) disable iff (!rst_n)
    ev_flush |=> dep <= $past(dep));

  assert_csr_load_R9: assert property (@(posedge clk) disable iff (!rst_n)
    csr_we_i && csr_wdata_i[DEP_LSB +: DEP_W] <= DEP_MAX |=> csr_rdata_o == $past(csr_wdata_i));
endmodule

bind opg_stack_ctrl opg_stack_chk u_chk (
  .clk            (clk),
  .rst_n          (rst_n),
  .retire_i       (retire_i),
  .ctl_push_i     (ctl_push_i),
  .ctl_pop_i      (ctl_pop_i),
  .ctl_reset_i    (ctl_reset_i),
  .branch_taken_i (branch_taken_i),
  .csr_we_i       (csr_we_i),
  .csr_wdata_i    (csr_wdata_i),
  .csr_rdata_o    (csr_rdata_o),
  .active_page_o  (active_page_o),
  .default_isa_o  (default_isa_o),
  .overflow_o     (overflow_o),
  .ev_push_ok     (ev_push_ok),
  .ev_push_drop   (ev_push_drop),
  .ev_expire      (ev_expire),
  .ev_flush       (ev_flush)
);

// File: tb/tb_opg_stack_ctrl.sv
module tb_opg_stack_ctrl;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        retire, push, pop, rdef, br, we;
  logic [2:0]  pg;
  logic [3:0]  ln;
  logic [31:0] wd;
  logic [31:0] rd;
  logic [2:0]  apage;
  logic        dflt, ovf;

  always #5 clk = ~clk;

  opg_stack_ctrl dut (
    .clk(clk), .rst_n(rst_n), .retire_i(retire), .ctl_push_i(push),
    .push_page_i(pg), .push_len_i(ln), .ctl_pop_i(pop), .ctl_reset_i(rdef),
    .branch_taken_i(br), .csr_we_i(we), .csr_wdata_i(wd), .csr_rdata_o(rd),
    .active_page_o(apage), .default_isa_o(dflt), .overflow_o(ovf)
  );

  typedef struct {
    logic [31:0] rd;
    logic [2:0]  pg;
    logic        dflt;
    logic        ovf;
    string       tag;
  } exp_t;

  exp_t q[$];
  int checks = 0;
  int failures = 0;
  int mpg[4];
  int mln[4];
  int md = 0;
  int movf = 0;

  function automatic logic [31:0] mpack();
    logic [31:0] r;
    r = '0;
    for (int k = 0; k < 4; k++) begin
      r[k*7 +: 4]   = 4'(mln[k]);
      r[k*7+4 +: 3] = 3'(mpg[k]);
    end
    r[30:28] = 3'(md);
    r[31]    = movf[0];
    return r;
  endfunction

  task automatic idle_inputs();
    retire = 0; push = 0; pop = 0; rdef = 0; br = 0; we = 0;
    pg = '0; ln = '0; wd = '0;
  endtask

  // Driver: applies one cycle of stimulus, updates the reference model, queues the expectation.
  task automatic drive(input logic w, input logic [31:0] wdat, input logic r, input logic p,
                       input logic u, input int page, input int len, input logic b,
                       input logic t, input string tag);
    exp_t e;
    int kp[4];
    int kl[4];
    int kn;
    @(negedge clk);
    we = w; wd = wdat; rdef = r; pop = p; push = u; pg = 3'(page); ln = 4'(len);
    br = b; retire = t;
    if (w) begin
      for (int k = 0; k < 4; k++) begin
        mln[k] = int'(wdat[k*7 +: 4]);
        mpg[k] = int'(wdat[k*7+4 +: 3]);
      end
      md = int'(wdat[30:28]);
      if (md > 4) md = 4;
      movf = int'(wdat[31]);
    end else if (r) begin
      for (int k = 0; k < 4; k++) begin mpg[k] = 0; mln[k] = 0; end
      md = 0;
    end else if (p) begin
      if (md > 0) begin mpg[md-1] = 0; mln[md-1] = 0; md--; end
    end else if (u) begin
      if (len != 0) begin
        if (md < 4) begin mpg[md] = page; mln[md] = len; md++; end
        else movf = 1;
      end
    end else if (b) begin
      kn = 0;
      for (int k = 0; k < 4; k++) begin kp[k] = 0; kl[k] = 0; end
      for (int k = 0; k < md; k++) begin
        if (mln[k] == 15) begin kp[kn] = mpg[k]; kl[kn] = mln[k]; kn++; end
      end
      for (int k = 0; k < 4; k++) begin mpg[k] = kp[k]; mln[k] = kl[k]; end
      md = kn;
    end else if (t) begin
      if (md > 0 && mln[md-1] != 15) begin
        if (mln[md-1] <= 1) begin mpg[md-1] = 0; mln[md-1] = 0; md--; end
        else mln[md-1]--;
      end
    end
    e.rd   = mpack();
    e.pg   = (md == 0) ? 3'd0 : 3'(mpg[md-1]);
    e.dflt = (md == 0);
    e.ovf  = movf[0];
    e.tag  = tag;
    q.push_back(e);
    @(posedge clk);
    #1 idle_inputs();
  endtask

  task automatic do_push(input int page, input int len, input string tag);
    drive(0, '0, 0, 0, 1, page, len, 0, 0, tag);
  endtask
  task automatic do_pop(input string tag);
    drive(0, '0, 0, 1, 0, 0, 0, 0, 0, tag);
  endtask
  task automatic do_retire(input string tag);
    drive(0, '0, 0, 0, 0, 0, 0, 0, 1, tag);
  endtask
  task automatic do_branch(input string tag);
    drive(0, '0, 0, 0, 0, 0, 0, 1, 0, tag);
  endtask
  task automatic do_rdef(input string tag);
    drive(0, '0, 1, 0, 0, 0, 0, 0, 0, tag);
  endtask
  task automatic do_csr(input logic [31:0] v, input string tag);
    drive(1, v, 0, 0, 0, 0, 0, 0, 0, tag);
  endtask

  // Monitor: results are due one rising edge after the stimulus cycle.
  initial begin
    exp_t e;
    forever begin
      @(posedge clk);
      #3;
      if (q.size() > 0) begin
        e = q.pop_front();
        checks++;
        if (rd !== e.rd || apage !== e.pg || dflt !== e.dflt || ovf !== e.ovf) begin
          failures++;
          $display("FAIL %s: got rdata=%h page=%0d dflt=%b ovf=%b, expected rdata=%h page=%0d dflt=%b ovf=%b",
                   e.tag, rd, apage, dflt, ovf, e.rd, e.pg, e.dflt, e.ovf);
        end
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    failures++;
    $display("FAIL watchdog: run did not complete, expected completion");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    for (int k = 0; k < 4; k++) begin mpg[k] = 0; mln[k] = 0; end
    idle_inputs();
    rst_n = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    checks++;
    if (rd !== 32'h0 || dflt !== 1'b1 || apage !== 3'd0 || ovf !== 1'b0) begin
      failures++;
      $display("FAIL R1 reset: got rdata=%h dflt=%b page=%0d ovf=%b, expected 0 1 0 0",
               rd, dflt, apage, ovf);
    end

    do_push(5, 3, "R2 push page");
    do_retire("R4 countdown 3->2");
    do_retire("R4 countdown 2->1");
    do_retire("R4 expiry pops, R10 default view");
    do_push(6, 0, "R2 zero-length push ignored");

    do_push(1, 15, "R2 push permanent");
    do_push(2, 2, "R2 push second");
    do_push(3, 15, "R2 push third permanent");
    do_push(4, 5, "R2 push to full");
    do_push(6, 1, "R3 push at full dropped, overflow set");
    do_retire("R4 countdown top 5->4");
    do_branch("R8 branch keeps permanent entries packed");
    do_retire("R5 permanent top holds");
    do_retire("R5 permanent top holds again");
    do_pop("R6 pop top");
    do_pop("R6 pop last");
    do_pop("R6 pop at depth 0 no effect");
    do_retire("R3 overflow remains sticky");

    drive(1, 32'h7F | (32'h23 << 7) | (32'd2 << 28), 1, 0, 0, 0, 0, 0, 0,
          "R9 status write beats reset-to-default");
    do_retire("R4 countdown after restore");
    do_retire("R4 countdown after restore to 1");
    do_retire("R4 restored entry expires");
    do_retire("R5 restored permanent holds");
    do_csr(32'h8000_0000 | (32'd7 << 28) | 32'h0123_4567, "R9 depth clamped to 4");
    do_rdef("R7 reset-to-default clears stack, keeps overflow");
    do_csr(32'h0, "R9 status write clears overflow, R3");

    do_push(3, 4, "R2 push before priority tests");
    drive(0, '0, 0, 1, 1, 7, 6, 0, 0, "R11 pop beats push");
    do_push(2, 9, "R2 push again");
    drive(0, '0, 0, 0, 1, 5, 15, 1, 0, "R11 push beats branch");
    drive(0, '0, 0, 0, 1, 6, 3, 0, 1, "R4 R11 push with retire, no countdown");
    drive(0, '0, 1, 1, 1, 1, 1, 0, 0, "R11 reset beats pop and push");
    do_push(4, 2, "R2 push non-permanent");
    drive(0, '0, 0, 0, 0, 0, 0, 1, 1, "R8 branch with retire removes entry");

    @(posedge clk);
    #5;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule